// File: doc/BRIEF.md
# Nibble-RAM ROM bank mapper

This block is the bank controller for a cartridge. It sits on a CPU bus with 16-bit addresses and 8-bit data. The CPU sees 32 KB of ROM. The lower 16 KB always show the first ROM bank. The upper 16 KB show a bank that software picks by writing a bank number into the lower ROM range. The block drives the physical ROM address and steers read data back to the CPU. Read data comes either from the external ROM data input or from a small built-in RAM.

The built-in RAM holds 512 entries of four bits each. It sits in the external-RAM window at 0xA000–0xBFFF. Only the low nibble of a write is kept. Reads return that nibble with the upper nibble at zero. Every address the block does not map reads as 0xFF.

Reads are combinational from the address. Writes, both to the bank select and to the RAM, take effect at the rising clock edge. The number of ROM banks is the parameter `ROM_BANKS`.

Top module: `nib_bank_mapper`

## Requirements
- R1: For addresses 0x0000–0x3FFF, `rom_addr` equals the CPU address with all bank bits at zero, and `cpu_rdata` equals `rom_rdata`.
- R2: For addresses 0x4000–0x7FFF, `rom_addr` equals bank × 0x4000 + (address − 0x4000), and `cpu_rdata` equals `rom_rdata`.
- R3: A write to 0x2000–0x3FFF sets the bank to bits [3:0] of the data taken modulo `ROM_BANKS`. Bits [7:4] are ignored. The new bank is seen from the cycle after the write edge.
- R4: If the result of R3 is 0, bank 1 is selected instead. The bank is therefore never 0.
- R5: After a synchronous active-high reset, the selected bank is 1.
- R6: Writes to 0x0000–0x1FFF and to 0x4000–0x7FFF leave the bank unchanged.
- R7: A write in 0xA000–0xBFFF stores data bits [3:0] in the RAM entry. A read there returns 0x0 in bits [7:4] and the stored nibble in bits [3:0].
- R8: The RAM entry index is address bits [8:0], so addresses 512 entries apart in the window hit the same entry.
- R9: Reads of 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF.
- R10: Read data follows the address with no clock. During a RAM write cycle the old contents are read, and from the next cycle the new contents are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising edge |
| rom_rdata | input | 8 | Data returned by the external ROM |
| rom_addr | output | $clog2(ROM_BANKS)+14 | Physical ROM address |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
A RAM write and a RAM read of the same entry can fall in the same cycle. This is because the read path is combinational while the store happens at the edge. The bench first places a known nibble, then holds a write of a different nibble to that address. It samples `cpu_rdata` before the edge and expects the old nibble, then samples it after the edge and expects the new one. A bank-select write followed at once by an upper-window read is judged the same way: the old bank is expected before the edge and the new one after it.

// File: rtl/nib_bank_pkg.sv
package nib_bank_pkg;

    typedef enum logic [1:0] {
        RG_ROM_LO = 2'd0,
        RG_ROM_HI = 2'd1,
        RG_RAM    = 2'd2,
        RG_NONE   = 2'd3
    } region_e;

    localparam int unsigned WIN_OFF_W = 14;
    localparam int unsigned RAM_DEPTH = 512;
    localparam int unsigned RAM_IDX_W = $clog2(RAM_DEPTH);
    localparam logic [7:0]  OPEN_BUS  = 8'hFF;

    function automatic region_e region_of(input logic [15:0] a);
        region_e r;
        unique casez (a[15:13])
            3'b00?:  r = RG_ROM_LO;
            3'b01?:  r = RG_ROM_HI;
            3'b101:  r = RG_RAM;
            default: r = RG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] fold_bank(input logic [3:0] raw, input int unsigned nbanks);
        int unsigned r;
        r = 32'(raw) % nbanks;
        if (r == 0) r = 1;
        return 4'(r);
    endfunction

endpackage

// File: rtl/nib_addr_decode.sv
module nib_addr_decode
    import nib_bank_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        wr,
    output region_e     region,
    output logic        sel_we,
    output logic        ram_we
);
    always_comb begin
        region = region_of(addr);
        sel_we = wr && (addr[15:13] == 3'b001);
        ram_we = wr && (region == RG_RAM);
    end
endmodule

// File: rtl/nib_bank_select.sv
module nib_bank_select
    import nib_bank_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 8,
    localparam int unsigned BANK_W   = (ROM_BANKS > 2) ? $clog2(ROM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [3:0]        sel_data,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= BANK_W'(1);
        else if (sel_we)
            bank_q <= BANK_W'(fold_bank(sel_data, ROM_BANKS));
    end

    assign bank = bank_q;

    assert_bank_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        bank_q != '0);

    assert_bank_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        32'(bank_q) < ROM_BANKS);

    assert_bank_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(sel_we) && !$past(rst)) |-> $stable(bank_q));
endmodule

// File: rtl/nib_ram.sv
module nib_ram
    import nib_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [RAM_IDX_W-1:0] idx,
    input  logic [3:0]           wdata,
    output logic [3:0]           rdata
);
    logic [3:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

    assert_ram_store_R7: assert property (@(posedge clk) disable iff (rst)
        $past(we) |-> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/nib_bank_mapper.sv
module nib_bank_mapper
    import nib_bank_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 8,
    localparam int unsigned BANK_W   = (ROM_BANKS > 2) ? $clog2(ROM_BANKS) : 1,
    localparam int unsigned ROM_AW   = BANK_W + WIN_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic [7:0]        rom_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [7:0]        cpu_rdata
);
    region_e           region;
    logic              sel_we;
    logic              ram_we;
    logic [BANK_W-1:0] bank;
    logic [3:0]        ram_nib;
    logic              unused_hi;

    assign unused_hi = ^cpu_wdata[7:4];

    nib_addr_decode u_dec (
        .addr   (cpu_addr),
        .wr     (cpu_wr),
        .region (region),
        .sel_we (sel_we),
        .ram_we (ram_we)
    );

    nib_bank_select #(.ROM_BANKS(ROM_BANKS)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_we   (sel_we),
        .sel_data (cpu_wdata[3:0]),
        .bank     (bank)
    );

    nib_ram u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .idx   (cpu_addr[RAM_IDX_W-1:0]),
        .wdata (cpu_wdata[3:0]),
        .rdata (ram_nib)
    );

    always_comb begin
        rom_addr = {(region == RG_ROM_HI) ? bank : BANK_W'(0), cpu_addr[WIN_OFF_W-1:0]};
        unique case (region)
            RG_ROM_LO, RG_ROM_HI: cpu_rdata = rom_rdata;
            RG_RAM:               cpu_rdata = {4'h0, ram_nib};
            default:              cpu_rdata = OPEN_BUS;
        endcase
    end

    assert_open_bus_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11) |-> cpu_rdata == 8'hFF);

    assert_ram_hi_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b101) |-> cpu_rdata[7:4] == 4'h0);

    assert_low_window_bank0_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_AW-1:WIN_OFF_W] == '0);
endmodule

// File: tb/nib_bank_mapper_tb.sv
module nib_bank_mapper_tb;
    localparam int unsigned NB = 8;
    localparam int unsigned AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   cpu_addr = 16'h0;
    logic [7:0]    cpu_wdata = 8'h0;
    logic          cpu_wr = 1'b0;
    logic [7:0]    rom_rdata;
    logic [AW-1:0] rom_addr;
    logic [7:0]    cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign rom_rdata = rom_addr[7:0] ^ {1'b0, rom_addr[16:14], 4'h5};

    nib_bank_mapper #(.ROM_BANKS(NB)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .rom_addr(rom_addr),
        .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] rom_model(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[16:14], 4'h5};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
    endtask

    task automatic expect_bank(input string tag, input int bank, input logic [15:0] a);
        logic [AW-1:0] exp_a;
        bus_rd(a);
        exp_a = AW'(bank * 32'h4000 + (32'(a) - 32'h4000));
        chk({tag, " addr"}, 32'(rom_addr), 32'(exp_a));
        chk({tag, " data"}, 32'(cpu_rdata), 32'(rom_model(exp_a)));
    endtask

    task automatic t_reset;
        expect_bank("R5 reset bank", 1, 16'h4000);
        bus_rd(16'h0123);
        chk("R1 low addr", 32'(rom_addr), 32'h0123);
        chk("R1 low data", 32'(cpu_rdata), 32'(rom_model(17'h0123)));
        bus_rd(16'h3FFF);
        chk("R1 low top", 32'(rom_addr), 32'h3FFF);
    endtask

    task automatic t_select;
        bus_wr(16'h2000, 8'h03);
        expect_bank("R2 bank3", 3, 16'h4567);
        bus_wr(16'h3FFF, 8'hF6);
        expect_bank("R3 upper bits ignored", 6, 16'h7FFF);
        bus_wr(16'h2ABC, 8'h0F);
        expect_bank("R3 wrap 15", 7, 16'h4001);
        bus_wr(16'h2000, 8'h09);
        expect_bank("R3 wrap 9", 1, 16'h5000);
        bus_wr(16'h2000, 8'h0D);
        expect_bank("R3 wrap 13", 5, 16'h6000);
    endtask

    task automatic t_zero;
        bus_wr(16'h2000, 8'h00);
        expect_bank("R4 zero", 1, 16'h4100);
        bus_wr(16'h2000, 8'h04);
        bus_wr(16'h2000, 8'h08);
        expect_bank("R4 wraps to zero", 1, 16'h4200);
    endtask

    task automatic t_ignored;
        bus_wr(16'h2000, 8'h02);
        bus_wr(16'h1000, 8'h05);
        expect_bank("R6 low write", 2, 16'h4300);
        bus_wr(16'h4000, 8'h06);
        bus_wr(16'h7FFF, 8'h07);
        expect_bank("R6 upper write", 2, 16'h4400);
    endtask

    task automatic t_ram;
        bus_wr(16'hA010, 8'hAB);
        bus_rd(16'hA010);
        chk("R7 nibble", 32'(cpu_rdata), 32'h0B);
        bus_wr(16'hA000, 8'h03);
        bus_rd(16'hA200);
        chk("R8 alias 512", 32'(cpu_rdata), 32'h03);
        bus_wr(16'hBFFF, 8'h5E);
        bus_rd(16'hA1FF);
        chk("R8 alias top", 32'(cpu_rdata), 32'h0E);
    endtask

    task automatic t_unmapped;
        bus_rd(16'h8000); chk("R9 8000", 32'(cpu_rdata), 32'hFF);
        bus_rd(16'h9FFF); chk("R9 9FFF", 32'(cpu_rdata), 32'hFF);
        bus_rd(16'hC000); chk("R9 C000", 32'(cpu_rdata), 32'hFF);
        bus_rd(16'hFFFF); chk("R9 FFFF", 32'(cpu_rdata), 32'hFF);
    endtask

    task automatic t_same_cycle;
        bus_wr(16'hA055, 8'h02);
        @(negedge clk);
        cpu_addr = 16'hA055; cpu_wdata = 8'h07; cpu_wr = 1'b1;
        #1;
        chk("R10 old during write", 32'(cpu_rdata), 32'h02);
        @(posedge clk);
        #1;
        chk("R10 new after edge", 32'(cpu_rdata), 32'h07);
        @(negedge clk);
        cpu_wr = 1'b0;
        bus_wr(16'h2000, 8'h04);
        cpu_addr = 16'h4800;
        #1;
        chk("R10 bank after edge", 32'(rom_addr), 32'h10800);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select();
        t_zero();
        t_ignored();
        t_ram();
        t_unmapped();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule